// File: doc/BRIEF.md
# Synchronous Flow-Through Burst Static RAM

This block is a synthesizable behavioural model of a small synchronous static RAM. The memory is organised in byte lanes. Address, strobes, chip enables and write controls are registered on the rising clock edge. Each access begins when either of two address strobes loads a base address. After that, a two-bit burst counter walks the next addresses. The counter moves forward in every continuation cycle in which the advance input is low.

Reads are flow-through. The word at the current registered address appears on the shared data bus during the same cycle that follows the loading edge. An asynchronous active-low output enable gates the bus. The bus also releases on its own whenever a write is being requested.

Writes come in two kinds. A global write stores every lane. A byte-write enable combined with per-lane selects stores only the chosen lanes. Three chip enables take part in selecting the device at each address load, which lets several devices share one address space.

Top module: `sync_burst_sram`

## Requirements
- R1: While reset is held and after it is released, the data bus is not driven until a selected address load has occurred.
- R2: After an edge that loads an address with the chip selected and no write, the bus carries that word during the next cycle, as long as oe_n is low.
- R3: With wr_all_n high and wr_byte_n low, a write stores only lanes whose lane_n bit is low. lane_n[i] governs dq[8i+7:8i]. With no lane selected, nothing changes.
- R4: With wr_all_n low, a write stores all lanes, whatever wr_byte_n and lane_n are.
- R5: A load by strb_cache_n (with strb_proc_n high) samples the write controls at the same edge. When a write is requested, the load address receives dq.
- R6: A load by strb_proc_n ignores the write controls at its own edge, and it takes priority when both strobes are low. A write in the following continuation cycle with adv_n high stores into the loaded address.
- R7: In a continuation cycle (both strobes high), adv_n low advances the burst count by one, modulo 4. With seq_mode low, the low two address bits are (base + count) mod 4 and the upper bits are held.
- R8: With seq_mode high, the low two address bits are base XOR count.
- R9: The chip is selected only if ce0_n=0, ce1=1 and ce2_n=0 at a load. A deselecting load releases the bus from the next cycle, and all writes are ignored until the next selected load.
- R10: oe_n high releases the bus at once, without waiting for a clock edge.
- R11: While wr_all_n or wr_byte_n is low, the block does not drive the bus.
- R12: A continuation cycle with adv_n high keeps the burst address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the access state |
| addr | input | AW | Load address |
| strb_proc_n | input | 1 | Address strobe; write controls taken from the next cycle |
| strb_cache_n | input | 1 | Address strobe; write controls taken in the same cycle |
| adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write, active low |
| wr_byte_n | input | 1 | Byte-write enable, active low |
| lane_n | input | NB | Per-lane write selects, active low |
| ce0_n | input | 1 | Chip enable, active low |
| ce1 | input | 1 | Chip enable, active high |
| ce2_n | input | 1 | Chip enable, active low |
| seq_mode | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq | inout | NB*8 | Shared read/write data bus |

## Verification
The bench pulls the bus high. All stored words keep bit 0 clear, so a released bus can always be told apart from a driven one.

A burst that wraps exposes a counter that carries into the upper address bits, or that uses the wrong order for the mode. Both show up as a wrong word on the bus.

A write issued together with a processor-strobe load corrupts the loaded word if the write controls are sampled at the wrong edge. An empty byte select that still writes changes a word that should stay untouched.

A deselecting load that leaves the block driving, or a write accepted while deselected, shows up as a driven bus or a changed word on the later readback. A bus that is not released during write requests collides with the data the bench is driving.

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int AW = 6,
  parameter int NB = 4,
  parameter int BW = 8,
  parameter int LB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          strb_proc_n,
  input  logic          strb_cache_n,
  input  logic          adv_n,
  input  logic          wr_all_n,
  input  logic          wr_byte_n,
  input  logic [NB-1:0] lane_n,
  input  logic          ce0_n,
  input  logic          ce1,
  input  logic          ce2_n,
  input  logic          seq_mode,
  input  logic          oe_n,
  inout  wire  [NB*BW-1:0] dq
);
  localparam int DW = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic          act_q;
  logic [AW-1:0] base_q;
  logic [LB-1:0] cnt_q, cnt_d;
  logic          proc_ld, cache_ld, load, sel, wr_now, act_d, do_wr;
  logic [AW-1:0] cur_a, eff_a;
  logic [DW-1:0] rd_word;

  function automatic logic [AW-1:0] burst_at(input logic [AW-1:0] b,
                                             input logic [LB-1:0] c,
                                             input logic m);
    logic [LB-1:0] lo;
    lo = m ? (b[LB-1:0] ^ c) : (b[LB-1:0] + c);
    return {b[AW-1:LB], lo};
  endfunction

  assign proc_ld  = ~strb_proc_n;
  assign cache_ld = ~strb_cache_n & strb_proc_n;
  assign load     = proc_ld | cache_ld;
  assign sel      = ~ce0_n & ce1 & ~ce2_n;
  assign wr_now   = ~wr_all_n | ~wr_byte_n;
  assign cnt_d    = load ? '0 : (adv_n ? cnt_q : cnt_q + LB'(1));
  assign act_d    = load ? sel : act_q;
  assign cur_a    = burst_at(base_q, cnt_q, seq_mode);
  assign eff_a    = load ? addr : burst_at(base_q, cnt_d, seq_mode);
  assign do_wr    = act_d & wr_now & ~proc_ld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
      if (load) base_q <= addr;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) begin
      for (int i = 0; i < NB; i++) begin
        if (~wr_all_n | ~lane_n[i]) mem[eff_a][i*BW +: BW] <= dq[i*BW +: BW];
      end
    end
  end

  assign rd_word = mem[cur_a];
  assign dq = (act_q & ~oe_n & ~wr_now) ? rd_word : {DW{1'bz}};
endmodule

module sync_burst_sram_chk #(
  parameter int AW = 6,
  parameter int LB = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          strb_proc_n,
  input logic          strb_cache_n,
  input logic          adv_n,
  input logic          ce0_n,
  input logic          ce1,
  input logic          ce2_n,
  input logic          act,
  input logic [AW-1:0] base,
  input logic [LB-1:0] cnt
);
  // R9
  desel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!strb_proc_n || !strb_cache_n) && !(!ce0_n && ce1 && !ce2_n)) |=> !act);

  // R7
  burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_proc_n && strb_cache_n && !adv_n) |=> cnt == LB'($past(cnt) + LB'(1)));

  // R12
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_proc_n && strb_cache_n && adv_n) |=> $stable(cnt) && $stable(base));

  // R6
  proc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb_proc_n |=> cnt == '0 && base == $past(addr));

  // R5
  cache_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_proc_n && !strb_cache_n) |=> cnt == '0 && base == $past(addr));
endmodule

bind sync_burst_sram sync_burst_sram_chk #(.AW(AW), .LB(LB)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .strb_proc_n(strb_proc_n),
  .strb_cache_n(strb_cache_n), .adv_n(adv_n), .ce0_n(ce0_n), .ce1(ce1),
  .ce2_n(ce2_n), .act(act_q), .base(base_q), .cnt(cnt_q)
);

// File: tb/sync_burst_sram_bench.sv
module sync_burst_sram_bench;
  localparam int AW = 6;
  localparam int NB = 4;
  localparam int BW = 8;
  localparam int LB = 2;
  localparam int DW = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic sp = 1'b1, sc = 1'b1, adv = 1'b1, wa = 1'b1, wb = 1'b1;
  logic [NB-1:0] ln = '1;
  logic c0 = 1'b0, c1 = 1'b1, c2 = 1'b0, md = 1'b0, oe = 1'b1;
  logic tb_drv = 1'b0;
  logic [DW-1:0] tb_data = '0;
  tri1 [DW-1:0] dq;
  assign dq = tb_drv ? tb_data : {DW{1'bz}};

  int checks = 0;
  int errors = 0;
  logic gmode = 1'b0;

  logic [DW-1:0] m_mem [DEPTH];
  logic m_act = 1'b0;
  logic [AW-1:0] m_base = '0;
  logic [LB-1:0] m_cnt = '0;

  always #10 clk = ~clk;

  sync_burst_sram #(.AW(AW), .NB(NB), .BW(BW), .LB(LB)) u_sync_burst_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .strb_proc_n(sp), .strb_cache_n(sc),
    .adv_n(adv), .wr_all_n(wa), .wr_byte_n(wb), .lane_n(ln), .ce0_n(c0),
    .ce1(c1), .ce2_n(c2), .seq_mode(md), .oe_n(oe), .dq(dq)
  );

  function automatic logic [AW-1:0] baddr(input logic [AW-1:0] b,
                                          input logic [LB-1:0] c, input logic m);
    logic [LB-1:0] lo;
    lo = m ? (b[LB-1:0] ^ c) : LB'(b[LB-1:0] + c);
    return {b[AW-1:LB], lo};
  endfunction

  task automatic check(input logic ok, input string tag,
                       input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic step(input logic [AW-1:0] a, input logic isp, input logic isc,
                      input logic iadv, input logic iwa, input logic iwb,
                      input logic [NB-1:0] iln, input logic ic0, input logic ic1,
                      input logic ic2, input logic ioe, input logic [DW-1:0] wd,
                      input string tag);
    logic wr, p, ld, s, nact;
    logic [LB-1:0] ncnt;
    logic [AW-1:0] eff;
    logic [DW-1:0] exp;
    addr = a; sp = isp; sc = isc; adv = iadv; wa = iwa; wb = iwb; ln = iln;
    c0 = ic0; c1 = ic1; c2 = ic2; oe = ioe; md = gmode;
    wr = ~iwa | ~iwb;
    tb_drv = wr; tb_data = wd;
    #8;
    if (wr) check(dq === wd, {tag, " R11"}, dq, wd);
    else if (m_act && !ioe) begin
      exp = m_mem[baddr(m_base, m_cnt, gmode)];
      check(dq === exp, tag, dq, exp);
    end else check(dq === {DW{1'b1}}, {tag, " released"}, dq, {DW{1'b1}});
    p = ~isp; ld = p | (~isc & isp); s = ~ic0 & ic1 & ~ic2;
    ncnt = ld ? '0 : (iadv ? m_cnt : LB'(m_cnt + LB'(1)));
    nact = ld ? s : m_act;
    eff = ld ? a : baddr(m_base, ncnt, gmode);
    @(posedge clk);
    if (rst_n) begin
      if (nact && wr && !p)
        for (int i = 0; i < NB; i++)
          if (!iwa || !iln[i]) m_mem[eff][i*BW +: BW] = wd[i*BW +: BW];
      if (ld) m_base = a;
      m_cnt = ncnt;
      m_act = nact;
    end
    @(negedge clk);
  endtask

  task automatic ld_wr(input logic [AW-1:0] a, input logic iwa, input logic iwb,
                       input logic [NB-1:0] iln, input logic [DW-1:0] wd, input string tag);
    step(a, 1, 0, 1, iwa, iwb, iln, 0, 1, 0, 0, wd, tag);
  endtask

  task automatic ld_rd(input logic [AW-1:0] a, input string tag);
    step(a, 1, 0, 1, 1, 1, '1, 0, 1, 0, 0, '0, tag);
  endtask

  task automatic cont(input logic iadv, input logic iwa, input logic iwb,
                      input logic [NB-1:0] iln, input logic ioe,
                      input logic [DW-1:0] wd, input string tag);
    step('0, 1, 1, iadv, iwa, iwb, iln, 0, 1, 0, ioe, wd, tag);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    step('0, 1, 1, 1, 1, 1, '1, 0, 1, 0, 0, '0, "R1 in reset");
    rst_n = 1'b1;
    cont(1, 1, 1, '1, 0, '0, "R1 after reset");

    for (int a = 0; a < DEPTH; a++)
      ld_wr(AW'(a), 0, 1, '1, DW'($urandom) & ~DW'(1), "R4 fill");

    ld_rd(5, "R2 load");
    cont(1, 1, 1, '1, 0, '0, "R2 flow-through read");
    cont(1, 1, 1, '1, 1, '0, "R10 oe high");
    cont(1, 1, 1, '1, 0, '0, "R10 oe low again");

    gmode = 1'b0;
    ld_rd(6, "R7 load");
    for (int k = 0; k < 5; k++) cont(0, 1, 1, '1, 0, '0, "R7 linear burst");
    cont(1, 1, 1, '1, 0, '0, "R12 hold");
    cont(1, 1, 1, '1, 0, '0, "R12 hold");

    gmode = 1'b1;
    ld_rd(9, "R8 load");
    for (int k = 0; k < 5; k++) cont(0, 1, 1, '1, 0, '0, "R8 interleaved burst");
    gmode = 1'b0;

    ld_wr(12, 1, 0, 4'b1010, 32'hA5C3_7E10, "R3 R5 lane write");
    cont(1, 1, 1, '1, 0, '0, "R3 readback");
    ld_wr(12, 1, 0, 4'b1111, 32'h0000_0000, "R3 empty select");
    cont(1, 1, 1, '1, 0, '0, "R3 empty select readback");
    ld_wr(13, 0, 1, 4'b1111, 32'h1234_5678, "R4 global write");
    cont(1, 1, 1, '1, 0, '0, "R4 readback");

    step(20, 0, 1, 1, 0, 1, '1, 0, 1, 0, 0, 32'hFFFF_0000, "R6 proc load");
    cont(1, 1, 1, '1, 0, '0, "R6 no write at load");
    cont(1, 0, 1, '1, 0, 32'h0BAD_F00C, "R6 next-cycle write");
    cont(1, 1, 1, '1, 0, '0, "R6 readback");
    step(21, 0, 0, 1, 1, 1, '1, 0, 1, 0, 0, '0, "R6 both strobes");
    cont(1, 1, 1, '1, 0, '0, "R6 proc priority read");

    step(3, 1, 0, 1, 1, 1, '1, 0, 0, 0, 0, '0, "R9 deselect ce1");
    cont(1, 1, 1, '1, 0, '0, "R9 released");
    cont(1, 0, 1, '1, 0, 32'h5555_5554, "R9 ignored write");
    step(4, 1, 0, 1, 0, 1, '1, 1, 1, 0, 0, 32'h3333_3332, "R9 deselected ce0 write");
    step(4, 1, 0, 1, 0, 1, '1, 0, 1, 1, 0, 32'h2222_2222, "R9 deselected ce2 write");
    ld_rd(3, "R9 reselect");
    cont(1, 1, 1, '1, 0, '0, "R9 readback 3");
    ld_rd(4, "R9 reselect");
    cont(1, 1, 1, '1, 0, '0, "R9 readback 4");

    for (int blk = 0; blk < 10; blk++) begin
      gmode = blk[0];
      for (int n = 0; n < 300; n++) begin
        logic r_sp, r_sc, r_wr, r_g;
        r_sp = ($urandom % 8) != 0;
        r_sc = ($urandom % 6) != 0;
        r_wr = ($urandom % 3) == 0;
        r_g = $urandom % 2;
        step(AW'($urandom), r_sp, r_sc, 1'($urandom), r_wr ? !r_g : 1'b1,
             r_wr ? r_g : 1'b1, NB'($urandom), ($urandom % 10) == 0,
             ($urandom % 10) != 0, ($urandom % 10) == 0, ($urandom % 5) == 0,
             DW'($urandom) & ~DW'(1), "random R2 R3 R7 R9");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule